// File: doc/BRIEF.md
# Virtual Interrupt CPU Interface

This block is the guest-facing side of a virtualised interrupt controller for one virtual CPU. A hypervisor-side block loads a small bank of list entries, each holding a virtual interrupt ID, a source CPU ID, a priority and a two-bit state. The guest reaches the entries through a 32-bit register port. Reading the acknowledge register picks the most urgent pending entry, returns its identity and marks it active. Writing the end-of-interrupt register names an entry by virtual ID and source CPU and retires it.

A level virtual IRQ output tells the guest CPU that work is waiting. Read data is registered: it appears on `reg_rdata` on the clock edge that samples the read. All list-entry state is exported as a packed vector so that the hypervisor side can see it.

Top module: `vcpu_irq_if`

## Requirements
- R1: An acknowledge read (offset 0x0C) returns 1023 when no entry is pending, or when the enable bit (bit 0 of the control register at offset 0x00) is clear. In that case no entry changes state.
- R2: Otherwise the acknowledge value holds the selected entry's virtual ID in bits [9:0] and its source CPU ID in bits [12:10]. All other bits are zero.
- R3: The state encoding is 0 invalid, 1 pending, 2 active and 3 pending+active. An acknowledge moves the selected entry from state 1 or 3 to state 2. Entry i's state appears on `lr_states[2i+1:2i]`.
- R4: Among the entries whose state bit 0 is set, the one with the numerically lowest priority is selected. When priorities tie, the lowest index wins.
- R5: In an end-of-interrupt write (offset 0x10), data bits [9:0] are the virtual ID and bits [12:10] are the source CPU. The lowest-index non-invalid entry that matches both fields goes to state 0.
- R6: An end-of-interrupt write that matches no non-invalid entry leaves every entry unchanged.
- R7: `virq` rises one cycle after the state shows a pending entry while enable is set.
- R8: Once `virq` is high, it stays high while any entry is pending, even if enable is cleared. It falls one cycle after no entry is pending.
- R9: The priority mask register (offset 0x04) stores and reads back bits [7:0] of the written data. The control register reads back only its enable bit.
- R10: A read of offset 0xFC returns the `ID_VALUE` parameter.
- R11: An access to any other offset behaves as follows. A read returns zero, and a write changes no register. `err` is high for the one cycle after the access.
- R12: A hypervisor load to an entry takes priority over an acknowledge of that same entry in the same cycle. The acknowledge still returns the entry's contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| err | output | 1 | Unmapped access flag, one cycle |
| lr_wr | input | 1 | Hypervisor list entry load strobe |
| lr_idx | input | IDX_W | Entry to load |
| lr_vid | input | ID_W | Virtual ID to load |
| lr_cpu | input | CPU_W | Source CPU ID to load |
| lr_prio | input | PRIO_W | Priority to load |
| lr_state | input | 2 | State to load |
| lr_states | output | 2*NUM_LR | Packed state of all entries |
| virq | output | 1 | Virtual IRQ to the guest CPU |

## Verification
Two functions can act in the same cycle: a hypervisor load of an entry and a guest acknowledge. To provoke the overlap, the bench raises `lr_wr` and `reg_rd` at offset 0x0C together. It does this once with the load aimed at the entry the acknowledge selects, and once with the load aimed at a different entry. The bench then judges the returned acknowledge value against the pre-load contents, and judges each entry's final state. The loaded state must win on the shared entry, and both effects must land when the entries differ.

// File: rtl/vcpu_irq_if.sv
module vcpu_irq_if #(
  parameter int          NUM_LR   = 4,
  parameter int          PRIO_W   = 5,
  parameter int          ID_W     = 10,
  parameter int          CPU_W    = 3,
  parameter int          AW       = 8,
  parameter logic [31:0] ID_VALUE = 32'h0102_043B
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_rd,
  input  logic                       reg_wr,
  input  logic [AW-1:0]              reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       err,
  input  logic                       lr_wr,
  input  logic [$clog2(NUM_LR)-1:0]  lr_idx,
  input  logic [ID_W-1:0]            lr_vid,
  input  logic [CPU_W-1:0]           lr_cpu,
  input  logic [PRIO_W-1:0]          lr_prio,
  input  logic [1:0]                 lr_state,
  output logic [2*NUM_LR-1:0]        lr_states,
  output logic                       virq
);
  localparam int IDX_W = $clog2(NUM_LR);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] OFS_PMR  = AW'(8'h04);
  localparam logic [AW-1:0] OFS_ACK  = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_EOI  = AW'(8'h10);
  localparam logic [AW-1:0] OFS_ID   = AW'(8'hFC);
  localparam logic [31:0]   NOINT    = 32'd1023;

  logic [ID_W-1:0]   vid_q  [NUM_LR];
  logic [CPU_W-1:0]  cpu_q  [NUM_LR];
  logic [PRIO_W-1:0] prio_q [NUM_LR];
  logic [1:0]        st_q   [NUM_LR];

  logic       en_q;
  logic [7:0] pmr_q;

  logic             any_pend, sel_ok, eoi_hit;
  logic [IDX_W-1:0] sel_idx, eoi_idx;
  logic [PRIO_W-1:0] best;

  always_comb begin
    sel_ok  = 1'b0;
    sel_idx = '0;
    best    = '0;
    for (int i = 0; i < NUM_LR; i++)
      if (st_q[i][0] && (!sel_ok || prio_q[i] < best)) begin
        sel_ok  = 1'b1;
        sel_idx = IDX_W'(i);
        best    = prio_q[i];
      end
  end
  assign any_pend = sel_ok;

  always_comb begin
    eoi_hit = 1'b0;
    eoi_idx = '0;
    for (int i = NUM_LR-1; i >= 0; i--)
      if (st_q[i] != 2'd0 &&
          vid_q[i] == reg_wdata[ID_W-1:0] &&
          cpu_q[i] == reg_wdata[ID_W+CPU_W-1:ID_W]) begin
        eoi_hit = 1'b1;
        eoi_idx = IDX_W'(i);
      end
  end

  logic is_ack, ack_fire, eoi_fire, mapped;
  assign is_ack   = reg_addr == OFS_ACK;
  assign ack_fire = reg_rd && is_ack && en_q && any_pend;
  assign eoi_fire = reg_wr && reg_addr == OFS_EOI && eoi_hit;
  assign mapped   = reg_addr == OFS_CTRL || reg_addr == OFS_PMR || is_ack ||
                    reg_addr == OFS_EOI || reg_addr == OFS_ID;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        vid_q[g]  <= '0;
        cpu_q[g]  <= '0;
        prio_q[g] <= '0;
        st_q[g]   <= 2'd0;
      end else if (lr_wr && lr_idx == IDX_W'(g)) begin
        vid_q[g]  <= lr_vid;
        cpu_q[g]  <= lr_cpu;
        prio_q[g] <= lr_prio;
        st_q[g]   <= lr_state;
      end else if (ack_fire && sel_idx == IDX_W'(g)) begin
        st_q[g]   <= 2'd2;
      end else if (eoi_fire && eoi_idx == IDX_W'(g)) begin
        st_q[g]   <= 2'd0;
      end
    assign lr_states[2*g+1:2*g] = st_q[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      pmr_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) en_q  <= reg_wdata[0];
      if (reg_addr == OFS_PMR)  pmr_q <= reg_wdata[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {31'd0, en_q};
        OFS_PMR:  reg_rdata <= {24'd0, pmr_q};
        OFS_ACK:  reg_rdata <= ack_fire ? 32'({cpu_q[sel_idx], vid_q[sel_idx]}) : NOINT;
        OFS_ID:   reg_rdata <= ID_VALUE;
        default:  reg_rdata <= '0;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= 1'b0;
    else        err <= (reg_rd || reg_wr) && !mapped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    virq <= 1'b0;
    else if (virq) virq <= any_pend;
    else           virq <= en_q && any_pend;

  // R1
  noint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && is_ack && (!en_q || !any_pend) |=> reg_rdata == NOINT);
  // R7
  virq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !virq && en_q && any_pend |=> virq);
  // R8
  virq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !virq);
  // R8
  virq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    virq && any_pend |=> virq);
  // R10
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == OFS_ID |=> reg_rdata == ID_VALUE);
  // R11
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) && !mapped |=> err);
endmodule

// File: tb/vcpu_irq_if_test.sv
module vcpu_irq_if_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDV = 32'h0102_043B;

  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic err, lr_wr = 0, virq;
  logic [1:0] lr_idx = 0, lr_state = 0;
  logic [9:0] lr_vid = 0;
  logic [2:0] lr_cpu = 0;
  logic [4:0] lr_prio = 0;
  logic [7:0] lr_states;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcpu_irq_if #(.ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err(err), .lr_wr(lr_wr), .lr_idx(lr_idx), .lr_vid(lr_vid),
    .lr_cpu(lr_cpu), .lr_prio(lr_prio), .lr_state(lr_state),
    .lr_states(lr_states), .virq(virq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; tick; reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick; reg_wr = 0;
  endtask

  task automatic load(input int i, input int v, input int c, input int p, input int s);
    lr_wr = 1; lr_idx = 2'(i); lr_vid = 10'(v); lr_cpu = 3'(c);
    lr_prio = 5'(p); lr_state = 2'(s); tick; lr_wr = 0;
  endtask

  function automatic int st(input int i); return int'(lr_states[2*i +: 2]); endfunction

  task automatic clear_all;
    for (int i = 0; i < 4; i++) load(i, 0, 0, 0, 0);
    tick;
  endtask

  task automatic t_reset;
    chk(reg_rdata == 0, "R9 reset rdata", reg_rdata, 0);
    chk(virq == 0, "R7 reset virq", virq, 0);
    chk(lr_states == 0, "R3 reset states", lr_states, 0);
    chk(err == 0, "R11 reset err", err, 0);
  endtask

  task automatic t_ack_sel;
    logic [31:0] d;
    clear_all;
    wr(8'h00, 1);
    load(0, 20, 2, 9, 1);
    load(1, 33, 0, 4, 1);
    load(2, 40, 5, 4, 3);
    load(3, 99, 7, 0, 0);
    rd(8'h0C, d);
    chk(d == 33, "R4 tie lowest index", d, 33);
    chk(st(1) == 2, "R3 pending->active", st(1), 2);
    rd(8'h0C, d);
    chk(d == (40 | (5 << 10)), "R2 vid/cpu packing", d, 40 | (5 << 10));
    chk(st(2) == 2, "R3 pending+active->active", st(2), 2);
    rd(8'h0C, d);
    chk(d == (20 | (2 << 10)), "R4 remaining entry", d, 20 | (2 << 10));
    rd(8'h0C, d);
    chk(d == 1023, "R1 none pending", d, 1023);
    tick;
    chk(virq == 0, "R8 virq falls", virq, 0);
  endtask

  task automatic t_eoi;
    wr(8'h10, 32'(40 | (4 << 10)));
    chk(st(2) == 2, "R6 cpu mismatch ignored", st(2), 2);
    chk(lr_states == 8'b00_10_10_10, "R6 all unchanged", lr_states, 8'b00_10_10_10);
    wr(8'h10, 32'(33));
    chk(st(1) == 0, "R5 eoi invalidates", st(1), 0);
    wr(8'h10, 32'(40 | (5 << 10)));
    chk(st(2) == 0, "R5 eoi cpu match", st(2), 0);
    chk(st(0) == 2, "R5 others untouched", st(0), 2);
  endtask

  task automatic t_virq;
    logic [31:0] d;
    clear_all;
    wr(8'h00, 0);
    load(1, 7, 1, 3, 1);
    tick; tick;
    chk(virq == 0, "R7 disabled no virq", virq, 0);
    rd(8'h0C, d);
    chk(d == 1023, "R1 disabled ack", d, 1023);
    chk(st(1) == 1, "R1 disabled no change", st(1), 1);
    wr(8'h00, 1);
    tick;
    chk(virq == 1, "R7 virq rises", virq, 1);
    wr(8'h00, 0);
    tick; tick;
    chk(virq == 1, "R8 virq holds when disabled", virq, 1);
    wr(8'h00, 1);
    rd(8'h0C, d);
    chk(d == (7 | (1 << 10)), "R2 ack after enable", d, 7 | (1 << 10));
    tick;
    chk(virq == 0, "R8 virq drops", virq, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h04, 32'h1A5);
    rd(8'h04, d);
    chk(d == 32'hA5, "R9 pmr readback", d, 32'hA5);
    wr(8'h00, 32'h3);
    rd(8'h00, d);
    chk(d == 1, "R9 ctrl readback", d, 1);
    rd(8'hFC, d);
    chk(d == IDV, "R10 id value", d, IDV);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    chk(err == 1, "R11 err on write", err, 1);
    tick;
    chk(err == 0, "R11 err one cycle", err, 0);
    wr(8'h20, 0);
    rd(8'h20, d);
    chk(d == 0, "R11 reads zero", d, 0);
    chk(err == 1, "R11 err on read", err, 1);
    rd(8'h04, d);
    chk(d == 32'hA5, "R11 pmr unchanged", d, 32'hA5);
    rd(8'h00, d);
    chk(d == 1, "R11 ctrl unchanged", d, 1);
  endtask

  task automatic t_collide;
    clear_all;
    wr(8'h00, 1);
    load(0, 5, 1, 3, 1);
    lr_wr = 1; lr_idx = 0; lr_vid = 9; lr_cpu = 0; lr_prio = 1; lr_state = 1;
    reg_rd = 1; reg_addr = 8'h0C;
    tick;
    lr_wr = 0; reg_rd = 0;
    chk(reg_rdata == (5 | (1 << 10)), "R12 ack sees old contents", reg_rdata, 5 | (1 << 10));
    chk(st(0) == 1, "R12 load wins", st(0), 1);
    load(0, 0, 0, 0, 0);
    load(1, 7, 2, 2, 1);
    lr_wr = 1; lr_idx = 3; lr_vid = 11; lr_cpu = 3; lr_prio = 6; lr_state = 1;
    reg_rd = 1; reg_addr = 8'h0C;
    tick;
    lr_wr = 0; reg_rd = 0;
    chk(reg_rdata == (7 | (2 << 10)), "R12 ack other entry", reg_rdata, 7 | (2 << 10));
    chk(st(1) == 2 && st(3) == 1, "R12 both effects", lr_states, 8'b01_00_10_00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ack_sel;
    t_eoi;
    t_virq;
    t_regs;
    t_unmapped;
    t_collide;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule